// File: doc/BRIEF.md
# Audio Subframe Packing Formatter

This block sits between a multichannel audio sample stream and the word FIFO of a digital audio transmitter. Every accepted input word becomes exactly one 32-bit output word. In PCM mode the low 24 bits of the input are kept as the sample. The block then adds the consumer channel-status bit for the current frame and channel, a block-start flag and an even parity bit. It generates the whole 192-frame channel-status sequence itself from four configured status bytes. In repack mode the input already uses the standard subframe layout, and the block shifts it down into the transmitter layout.

A sequencer state machine keeps a channel index and a frame index. It has two states. ST_IDLE is the state after reset, and no input is accepted there. ST_RUN streams samples. The transition "arm" goes from ST_IDLE to ST_RUN on a start pulse. The transition "restart" goes from ST_RUN back to ST_RUN on a later start pulse. Both transitions clear the channel index and the frame index and capture mode, channel count and status bytes. A single output register gives a valid/ready output. Backpressure on that register stalls the input.

Top module: `subframe_packer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready stays 0 until the first start pulse.
- R2: In PCM mode, output bits 23..0 equal input bits 23..0. Input bits 31..24 are discarded, and output bits 31..29, 25 and 24 are 0.
- R3: In PCM mode, output bit 26 is channel-status bit k, where k is the frame index. Bit k is status_bytes[k] for k < 32: byte j sits in bits 8j+7..8j and is sent LSB first. For k from 32 to 191 the bit is 0.
- R4: For channel n (0..7), bits 23..20 of status_bytes (bits 7..4 of byte 2) are replaced by n+1 before this selection.
- R5: In PCM mode, output bit 28 is 1 only for channel 0 of frame 0.
- R6: In PCM mode, output bit 27 makes output bits 27..0 contain an even number of ones.
- R7: The channel index steps once per accepted word and wraps after the last channel. The frame index steps at that wrap and goes from 191 back to 0.
- R8: In repack mode (mode_sel = 1), output bits 27..0 equal input bits 31..4, output bit 28 equals input bit 3, and output bits 31..29 are 0.
- R9: A start pulse returns both indices to 0. Changes to mode_sel, chan_cnt and status_bytes are ignored except in a start cycle.
- R10: While out_valid is 1 and out_ready is 0, out_data holds its value. Every accepted input produces exactly one output word, in order.
- R11: A chan_cnt value outside 2..8 is treated as 2.
- R12: in_ready is 0 in any cycle in which start is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse: clears indices and captures configuration |
| mode_sel | input | 1 | 0 = PCM, 1 = repack |
| chan_cnt | input | 4 | Channels per frame, 2..8 |
| status_bytes | input | 32 | Four consumer channel-status bytes, byte 0 in bits 7..0 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when both are high |
| in_data | input | 32 | Input sample word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 32 | Formatted transmitter word |

## Verification
Two functions can land in the same cycle. The first is a restart pulse, which clears the indices and captures new settings. The second is the drain of a word already held in the output register under backpressure. The bench drives start pulses in the middle of a frame while out_ready is held low at random. It then expects two things. The held word, which was formatted with the old counters, must come out unchanged. The first word accepted after the pulse must carry the block-start flag and the new channel numbering. Channel wrap and frame wrap also meet on the last channel of frame 191. The model predicts the block flag on the next word to catch this.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    localparam int WORD_W    = 32;
    localparam int SAMPLE_W  = 24;
    localparam int MAX_CH    = 8;
    localparam int MIN_CH    = 2;
    localparam int BLOCK_LEN = 192;
    localparam int CS_BYTES  = 4;

    localparam int CH_W      = $clog2(MAX_CH);
    localparam int CNT_W     = $clog2(MAX_CH + 1);
    localparam int FRAME_W   = $clog2(BLOCK_LEN);
    localparam int CS_BITS   = CS_BYTES * 8;
    localparam int CS_IDX_W  = $clog2(CS_BITS);

    localparam int POS_BLOCK    = 28;
    localparam int POS_PARITY   = 27;
    localparam int POS_CS       = 26;
    localparam int PREAMBLE_BLK = 3;
    localparam int REPACK_SHIFT = 4;
    localparam int CHNUM_LO     = 20;
    localparam int CHNUM_W      = 4;

    typedef enum logic {
        MODE_PCM    = 1'b0,
        MODE_REPACK = 1'b1
    } fmt_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/sfp_seq.sv
module sfp_seq
    import sfp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode_in,
    input  logic [CNT_W-1:0]    chan_in,
    input  logic [CS_BITS-1:0]  cs_in,
    input  logic                adv,
    output logic                running,
    output logic [CH_W-1:0]     chan_idx,
    output logic [FRAME_W-1:0]  frame_idx,
    output fmt_mode_e           mode_q,
    output logic [CNT_W-1:0]    nch_q,
    output logic [CS_BITS-1:0]  cs_q
);
    seq_state_e state_q, state_d;
    logic       last_ch, last_frame;

    function automatic logic [CNT_W-1:0] clamp_ch(input logic [CNT_W-1:0] c);
        if (c < CNT_W'(MIN_CH) || c > CNT_W'(MAX_CH))
            return CNT_W'(MIN_CH);
        return c;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;   // arm
            ST_RUN:  state_d = ST_RUN;              // restart keeps ST_RUN
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running    = (state_q == ST_RUN);
        last_ch    = ({1'b0, chan_idx} == nch_q - CNT_W'(1));
        last_frame = (frame_idx == FRAME_W'(BLOCK_LEN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_idx  <= '0;
            frame_idx <= '0;
            mode_q    <= MODE_PCM;
            nch_q     <= CNT_W'(MIN_CH);
            cs_q      <= '0;
        end else if (start) begin
            chan_idx  <= '0;
            frame_idx <= '0;
            mode_q    <= fmt_mode_e'(mode_in);
            nch_q     <= clamp_ch(chan_in);
            cs_q      <= cs_in;
        end else if (adv) begin
            if (last_ch) begin
                chan_idx  <= '0;
                frame_idx <= last_frame ? '0 : frame_idx + FRAME_W'(1);
            end else begin
                chan_idx  <= chan_idx + CH_W'(1);
            end
        end
    end

    p_frame_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx < FRAME_W'(BLOCK_LEN));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !start && last_ch && last_frame) |=> (frame_idx == '0 && chan_idx == '0));

    p_chan_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, chan_idx} < nch_q) && (nch_q >= CNT_W'(MIN_CH)) && (nch_q <= CNT_W'(MAX_CH)));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(nch_q) && $stable(mode_q) && $stable(cs_q)));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (chan_idx == '0 && frame_idx == '0 && running));
endmodule

// File: rtl/sfp_cs_gen.sv
module sfp_cs_gen
    import sfp_pkg::*;
(
    input  logic [CS_BITS-1:0]  cs_q,
    input  logic [CH_W-1:0]     chan_idx,
    input  logic [FRAME_W-1:0]  frame_idx,
    output logic                cs_bit
);
    logic [CS_BITS-1:0] per_ch [MAX_CH];

    for (genvar ch = 0; ch < MAX_CH; ch++) begin : g_ch
        always_comb begin
            per_ch[ch] = cs_q;
            per_ch[ch][CHNUM_LO +: CHNUM_W] = CHNUM_W'(ch + 1);
        end
    end

    always_comb begin
        if (frame_idx < FRAME_W'(CS_BITS))
            cs_bit = per_ch[chan_idx][frame_idx[CS_IDX_W-1:0]];
        else
            cs_bit = 1'b0;
    end
endmodule

// File: rtl/sfp_pack.sv
module sfp_pack
    import sfp_pkg::*;
(
    input  fmt_mode_e           mode,
    input  logic [WORD_W-1:0]   data_in,
    input  logic                cs_bit,
    input  logic                blk,
    output logic [WORD_W-1:0]   word
);
    logic [WORD_W-1:0] pcm_body;
    logic [WORD_W-1:0] rep_body;

    always_comb begin
        pcm_body = '0;
        pcm_body[SAMPLE_W-1:0] = data_in[SAMPLE_W-1:0];
        pcm_body[POS_CS]       = cs_bit;
        pcm_body[POS_BLOCK]    = blk;

        rep_body = '0;
        rep_body[WORD_W-REPACK_SHIFT-1:0] = data_in[WORD_W-1:REPACK_SHIFT];
        rep_body[POS_BLOCK] = data_in[PREAMBLE_BLK];
    end

    always_comb begin
        unique case (mode)
            MODE_REPACK: word = rep_body;
            default: begin
                word = pcm_body;
                word[POS_PARITY] = ^pcm_body[POS_CS:0];
            end
        endcase
    end

    always_comb begin
        if (mode == MODE_PCM && !$isunknown(word))
            p_even_parity_r6: assert (^word[POS_PARITY:0] == 1'b0);
    end
endmodule

// File: rtl/subframe_packer.sv
module subframe_packer
    import sfp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode_sel,
    input  logic [CNT_W-1:0]    chan_cnt,
    input  logic [CS_BITS-1:0]  status_bytes,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data
);
    logic                running;
    logic [CH_W-1:0]     chan_idx;
    logic [FRAME_W-1:0]  frame_idx;
    fmt_mode_e           mode_q;
    logic [CNT_W-1:0]    nch_q;
    logic [CS_BITS-1:0]  cs_q;
    logic                cs_bit;
    logic                blk;
    logic                accept;
    logic [WORD_W-1:0]   word;

    always_comb begin
        in_ready = running && !start && (!out_valid || out_ready);
        accept   = in_valid && in_ready;
        blk      = (chan_idx == '0) && (frame_idx == '0);
    end

    sfp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_in   (mode_sel),
        .chan_in   (chan_cnt),
        .cs_in     (status_bytes),
        .adv       (accept),
        .running   (running),
        .chan_idx  (chan_idx),
        .frame_idx (frame_idx),
        .mode_q    (mode_q),
        .nch_q     (nch_q),
        .cs_q      (cs_q)
    );

    sfp_cs_gen u_cs (
        .cs_q      (cs_q),
        .chan_idx  (chan_idx),
        .frame_idx (frame_idx),
        .cs_bit    (cs_bit)
    );

    sfp_pack u_pack (
        .mode    (mode_q),
        .data_in (in_data),
        .cs_bit  (cs_bit),
        .blk     (blk),
        .word    (word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_no_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !in_ready);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !in_ready);

    p_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/test_subframe_packer.sv
module test_subframe_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_sel = 1'b0;
    logic [3:0]  chan_cnt = 4'd2;
    logic [31:0] status_bytes = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int nchk = 0;
    int nerr = 0;
    int n_in = 0;
    int n_out = 0;
    bit done = 0;

    int          r_ch = 0, r_fr = 0, r_n = 2;
    bit          r_rep = 0;
    logic [31:0] r_cs = '0;
    bit          r_first = 0;
    string       tag = "";

    logic [31:0] q_exp[$];
    bit          q_rep[$];
    bit          q_first[$];

    always #5 clk = ~clk;

    subframe_packer i_subframe_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
        .chan_cnt(chan_cnt), .status_bytes(status_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s act=%h exp=%h", what, tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] d);
        logic [31:0] w, csv;
        bit b;
        if (r_rep) return {3'b000, d[3], d[31:4]};
        csv = r_cs;
        csv[23:20] = 4'(r_ch + 1);
        b = (r_fr < 32) ? csv[r_fr] : 1'b0;
        w = {3'b000, (r_ch == 0 && r_fr == 0), 1'b0, b, 2'b00, d[23:0]};
        w[27] = ^w[26:0];
        return w;
    endfunction

    task automatic compare_out();
        logic [31:0] e;
        bit rp, fst;
        if (q_exp.size() == 0) begin
            chk(0, "R10 unexpected word", out_data, 32'h0);
            return;
        end
        e = q_exp.pop_front(); rp = q_rep.pop_front(); fst = q_first.pop_front();
        n_out++;
        if (rp) begin
            chk(out_data == e, "R8 repack word", out_data, e);
        end else begin
            chk(out_data[23:0] == e[23:0] && out_data[31:29] == e[31:29] && out_data[25:24] == 2'b00,
                "R2 sample field", out_data, e);
            chk(out_data[26] == e[26], "R3 R4 status bit", out_data, e);
            chk(out_data[28] == e[28], "R5 R7 block flag", out_data, e);
            chk(out_data[27] == e[27], "R6 parity", out_data, e);
            if (fst) chk(out_data[28] == 1'b1, "R9 restart to frame 0", out_data, e);
        end
    endtask

    task automatic step(input bit st, input int vpct, input int rpct);
        @(negedge clk);
        start     = st;
        in_valid  = ($urandom % 100) < vpct;
        in_data   = $urandom;
        out_ready = ($urandom % 100) < rpct;
        #1;
        if (st) begin
            chk(in_ready == 1'b0, "R12 in_ready during start", {31'b0, in_ready}, 32'h0);
            r_ch = 0; r_fr = 0; r_rep = mode_sel; r_cs = status_bytes;
            r_n = (chan_cnt < 2 || chan_cnt > 8) ? 2 : int'(chan_cnt);
            r_first = 1;
        end
        if (out_valid && out_ready) compare_out();
        if (in_valid && in_ready) begin
            q_exp.push_back(model(in_data));
            q_rep.push_back(r_rep);
            q_first.push_back(r_first);
            r_first = 0;
            n_in++;
            if (r_ch == r_n - 1) begin
                r_ch = 0;
                r_fr = (r_fr == 191) ? 0 : r_fr + 1;
            end else r_ch++;
        end
    endtask

    task automatic run_words(input int words, input int vpct, input int rpct);
        int target;
        target = n_in + words;
        while (n_in < target) step(0, vpct, rpct);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog R10 act=%0d exp=%0d", n_out, n_in);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(0, 100, 100);
            chk(in_ready == 1'b0, "R1 no accept before start", {31'b0, in_ready}, 32'h0);
        end

        tag = "pcm2";
        mode_sel = 0; chan_cnt = 4'd2; status_bytes = 32'h5A_F7_3C_A5;
        step(1, 0, 100);
        run_words(2 * 200, 80, 70);

        tag = "pcm8";
        chan_cnt = 4'd8; status_bytes = 32'hC3_0F_81_6E;
        step(1, 80, 30);
        for (int i = 0; i < 60; i++) begin
            step(0, 80, 50);
            if (i == 20) begin chan_cnt = 4'd3; mode_sel = 1; status_bytes = '1; end
        end
        mode_sel = 0; chan_cnt = 4'd8;
        step(1, 80, 20);
        run_words(8 * 40, 80, 60);

        tag = "pcm5";
        chan_cnt = 4'd5; status_bytes = 32'h12_34_56_78;
        step(1, 70, 0);
        run_words(5 * 35, 70, 60);

        tag = "R11 clamp";
        chan_cnt = 4'd15;
        step(1, 90, 50);
        run_words(2 * 10, 90, 80);
        chan_cnt = 4'd1;
        step(1, 90, 50);
        run_words(2 * 10, 90, 80);

        tag = "repack";
        mode_sel = 1; chan_cnt = 4'd6;
        step(1, 80, 10);
        run_words(60, 80, 60);

        tag = "drain";
        for (int i = 0; i < 6; i++) step(0, 0, 100);
        chk(out_valid == 1'b0, "R10 output drained", {31'b0, out_valid}, 32'h0);
        chk(q_exp.size() == 0 && n_out == n_in, "R10 one output per input", n_out, n_in);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule